// File: doc/BRIEF.md
# SYSREF and SYNC Mode Controller

This block produces the single internal SYNC/SYSREF level that is fanned out to the clock dividers and the SYSREF output path. Its behaviour comes from a pair of 2-bit fields, a mode field and a mux field. Depending on the pair, the output can follow the external sync pin through a polarity bit. It can follow the same pin but change only on divider boundaries. It can emit a finite burst of SYSREF pulses, started either by a pin transition or by a write of the burst-length register. It can also run SYSREF continuously, either while an external request is held or without any condition. Every result is registered on the distribution clock, so nothing happens unless that clock runs.

The SYSREF divider supplies `div_tc`, a one-cycle strobe at every half-period boundary of the SYSREF period. A pulse is high for one strobe interval and low for the next, which gives a 50% duty cycle. The burst and continuous paths share one pulse engine, a state machine with four states:

- `ST_IDLE`: no pulse activity.
- `ST_ARMED`: a burst has been accepted and waits for a boundary.
- `ST_HIGH`: the high half of a pulse.
- `ST_LOW`: the low half of a pulse.

The engine moves between these states as follows:

- IDLE→ARMED on an accepted trigger.
- IDLE→HIGH on a strobe while a continuous run is requested.
- ARMED→HIGH on a strobe.
- HIGH→LOW on a strobe.
- LOW→HIGH on a strobe while pulses remain or the run request holds.
- LOW→IDLE on a strobe otherwise.
- Any state→IDLE whenever the engine is not selected.

Top module: `sysref_sync_ctrl`

## Requirements
- R1: With mode=0 and mux=0 the output stays low whatever the pin, polarity or write strobe do.
- R2: With mode=1 and mux=0 the output equals (synchronized pin XOR polarity). A pin change reaches the output on the third clock edge, and a polarity change alone reaches it on the next edge, which gives a software-triggered sync.
- R3: The 2-bit burst-length field `pcnt` encodes bursts of 1, 2, 4 and 8 pulses for values 0, 1, 2 and 3.
- R4: With mode=2 and mux=2, a rising edge of (synchronized pin XOR polarity) starts one burst of the length in `pcnt`. A polarity toggle alone does the same, and a falling edge starts nothing.
- R5: With mode=3 and mux=2, a one-cycle `pcnt_wr` starts a burst of the length in `pcnt`, and pin edges start nothing.
- R6: With mode=0, mux=2 and `req_en`=1, pulses repeat while (pin XOR polarity) is high. With `req_en`=0 this pair gives no output.
- R7: In every pulse mode each pulse is high for exactly one `div_tc` interval. A pulse rises only on the edge after a strobe, and turn-off always completes the pulse in progress, so no shortened pulse appears.
- R8: With mode=1 and mux=1 the output takes the value (pin XOR polarity) only on a cycle where `div_tc` is high, and otherwise holds.
- R9: With mux=3, SYSREF pulses run continuously for any mode value.
- R10: A trigger that arrives while a burst is in progress is ignored, and the burst keeps its original length.
- R11: The pairs (0,1), (1,2), (2,0), (2,1), (3,0) and (3,1) give no output.
- R12: While reset is held, and right after it, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Distribution clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_tc | input | 1 | SYSREF divider half-period strobe |
| sync_pin | input | 1 | External sync pin, asynchronous |
| sync_pol | input | 1 | Pin polarity select |
| sync_mode | input | 2 | Mode field |
| sysref_mux | input | 2 | Mux field |
| pcnt | input | CNT_W | Burst-length code |
| pcnt_wr | input | 1 | Write strobe of the burst-length register |
| req_en | input | 1 | Enables request-gated SYSREF |
| sync_out | output | 1 | Retimed SYNC/SYSREF level |

## Verification
On every cycle, the assertions check four things. A pulse that has risen is never cut before the next strobe, and a pulse starts only on a strobe. The remaining-pulse count never grows while a burst runs. The quiet and reclocked selections hold the output as required. Only the bench scenarios can show the end-to-end behaviour: burst lengths for each code in each trigger mode, that the polarity bit acts as a trigger, that request-gated bursts end cleanly, and that every unlisted mode pair stays silent.

// File: rtl/sysref_pkg.sv
package sysref_pkg;

    localparam int FIELD_W = 2;

    typedef enum logic [1:0] {
        OSEL_OFF,
        OSEL_PIN,
        OSEL_RECLK,
        OSEL_ENGINE
    } osel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HIGH,
        ST_LOW
    } eng_st_e;

    typedef struct packed {
        osel_e osel;
        logic  trig_edge;
        logic  trig_wr;
        logic  run_cont;
        logic  run_req;
    } mode_ctl_t;

endpackage

// File: rtl/sysref_pin_sync.sv
module sysref_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            level_d <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            level_d <= level;
        end
    end

    always_comb begin
        level = chain_q[STAGES-1] ^ pol;
        rise  = level & ~level_d;
    end
endmodule

// File: rtl/sysref_mode_dec.sv
module sysref_mode_dec
    import sysref_pkg::*;
(
    input  logic [FIELD_W-1:0] mode,
    input  logic [FIELD_W-1:0] mux,
    input  logic               req_en,
    output mode_ctl_t          ctl
);
    always_comb begin
        ctl          = '0;
        ctl.osel     = OSEL_OFF;
        if (mux == 2'd3) begin
            ctl.osel     = OSEL_ENGINE;
            ctl.run_cont = 1'b1;
        end else begin
            case ({mode, mux})
                4'b01_00: ctl.osel = OSEL_PIN;
                4'b01_01: ctl.osel = OSEL_RECLK;
                4'b10_10: begin
                    ctl.osel      = OSEL_ENGINE;
                    ctl.trig_edge = 1'b1;
                end
                4'b11_10: begin
                    ctl.osel    = OSEL_ENGINE;
                    ctl.trig_wr = 1'b1;
                end
                4'b00_10: begin
                    if (req_en) begin
                        ctl.osel    = OSEL_ENGINE;
                        ctl.run_req = 1'b1;
                    end
                end
                default: ctl.osel = OSEL_OFF;
            endcase
        end
    end
endmodule

// File: rtl/sysref_pulse_fsm.sv
module sysref_pulse_fsm
    import sysref_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tc,
    input  logic             trig,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run,
    output logic             pulse_hi
);
    localparam int REM_W = 2 ** CNT_W;
    localparam logic [REM_W-1:0] MAXREM = REM_W'((2 ** (REM_W - 1)) - 1);

    eng_st_e          st_q, st_d;
    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] load_val;

    assign load_val = (REM_W'(1) << cnt) - REM_W'(1);

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (trig)          st_d = ST_ARMED;
                    else if (run && tc) st_d = ST_HIGH;
                end
                ST_ARMED: if (tc) st_d = ST_HIGH;
                ST_HIGH:  if (tc) st_d = ST_LOW;
                ST_LOW: begin
                    if (tc) st_d = ((rem_q != '0) || run) ? ST_HIGH : ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs and pulse bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (!en) begin
            rem_q <= '0;
        end else if (st_q == ST_IDLE && trig) begin
            rem_q <= load_val;
        end else if (st_q == ST_LOW && tc && rem_q != '0) begin
            rem_q <= rem_q - REM_W'(1);
        end
    end

    always_comb pulse_hi = (st_q == ST_HIGH);

    assert_high_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && !tc && en) |=> (st_q == ST_HIGH));

    assert_start_on_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && $past(st_q) != ST_HIGH) |-> $past(tc));

    assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= MAXREM);

    assert_no_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && en && trig) |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/sysref_sync_ctrl.sv
module sysref_sync_ctrl
    import sysref_pkg::*;
#(
    parameter int CNT_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_tc,
    input  logic             sync_pin,
    input  logic             sync_pol,
    input  logic [1:0]       sync_mode,
    input  logic [1:0]       sysref_mux,
    input  logic [CNT_W-1:0] pcnt,
    input  logic             pcnt_wr,
    input  logic             req_en,
    output logic             sync_out
);
    mode_ctl_t ctl;
    logic      level, rise;
    logic      trig, run, eng_en, pulse_hi;
    logic      sync_q;

    sysref_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sync_pin),
        .pol   (sync_pol),
        .level (level),
        .rise  (rise)
    );

    sysref_mode_dec u_dec (
        .mode   (sync_mode),
        .mux    (sysref_mux),
        .req_en (req_en),
        .ctl    (ctl)
    );

    always_comb begin
        eng_en = (ctl.osel == OSEL_ENGINE);
        trig   = (ctl.trig_edge & rise) | (ctl.trig_wr & pcnt_wr);
        run    = ctl.run_cont | (ctl.run_req & level);
    end

    sysref_pulse_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (eng_en),
        .tc       (div_tc),
        .trig     (trig),
        .cnt      (pcnt),
        .run      (run),
        .pulse_hi (pulse_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else begin
            unique case (ctl.osel)
                OSEL_OFF:    sync_q <= 1'b0;
                OSEL_PIN:    sync_q <= level;
                OSEL_RECLK:  sync_q <= div_tc ? level : sync_q;
                OSEL_ENGINE: sync_q <= pulse_hi;
            endcase
        end
    end

    assign sync_out = sync_q;

    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.osel == OSEL_OFF) |=> !sync_out);

    assert_reclk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.osel == OSEL_RECLK && !div_tc) |=> $stable(sync_out));
endmodule

// File: tb/sim_sysref_sync_ctrl.sv
`timescale 1ns/1ps
module sim_sysref_sync_ctrl;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_tc = 1'b0;
    logic       sync_pin = 1'b0;
    logic       sync_pol = 1'b0;
    logic [1:0] sync_mode = 2'd0;
    logic [1:0] sysref_mux = 2'd0;
    logic [1:0] pcnt = 2'd0;
    logic       pcnt_wr = 1'b0;
    logic       req_en = 1'b0;
    logic       sync_out;

    int nchk = 0, nfail = 0;
    int rises = 0, bad_w = 0, rise_on_tc = 0, rise_after_tc = 0;
    int hi_len = 0, phase = 0;
    logic prev_out = 1'b0, tc_prev = 1'b0;

    always #2 clk = ~clk;

    sysref_sync_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .div_tc(div_tc), .sync_pin(sync_pin),
        .sync_pol(sync_pol), .sync_mode(sync_mode), .sysref_mux(sysref_mux),
        .pcnt(pcnt), .pcnt_wr(pcnt_wr), .req_en(req_en), .sync_out(sync_out)
    );

    // monitor and half-period strobe generator, just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (sync_out && !prev_out) begin
                rises++;
                if (div_tc)  rise_on_tc++;
                if (tc_prev) rise_after_tc++;
            end
            if (sync_out) hi_len++;
            if (!sync_out && prev_out) begin
                if (hi_len != HALF) bad_w++;
                hi_len = 0;
            end
            prev_out = sync_out;
            tc_prev  = div_tc;
            phase    = (phase + 1) % HALF;
            div_tc   = (phase == 0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        rises = 0; bad_w = 0; rise_on_tc = 0; rise_after_tc = 0;
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setmode(int m, int x, bit r);
        @(negedge clk);
        sync_mode = 2'(m); sysref_mux = 2'(x); req_en = r;
        tick(HALF * 3);
        clr();
    endtask

    task automatic wr_pulse(int p);
        @(negedge clk);
        pcnt = 2'(p); pcnt_wr = 1'b1;
        @(negedge clk);
        pcnt_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        tick(3);
        chk(sync_out == 1'b0, "R12 in reset", int'(sync_out), 0);
        rst_n = 1'b1;
        tick(2);
        chk(sync_out == 1'b0, "R12 after reset", int'(sync_out), 0);

        // R1: mode 0 / mux 0
        setmode(0, 0, 1'b0);
        sync_pin = 1'b1; tick(10); sync_pol = 1'b1; tick(10);
        wr_pulse(3); tick(10); sync_pin = 1'b0; sync_pol = 1'b0; tick(10);
        chk(rises == 0 && sync_out == 1'b0, "R1 off pair quiet", rises, 0);

        // R2: pin follower with latency
        setmode(1, 0, 1'b0);
        sync_pin = 1'b1; tick(2);
        chk(sync_out == 1'b0, "R2 pin latency early", int'(sync_out), 0);
        tick(1);
        chk(sync_out == 1'b1, "R2 pin latency third edge", int'(sync_out), 1);
        sync_pin = 1'b0; tick(3);
        chk(sync_out == 1'b0, "R2 pin low", int'(sync_out), 0);
        sync_pol = 1'b1; tick(1);
        chk(sync_out == 1'b1, "R2 polarity toggle sync", int'(sync_out), 1);
        sync_pol = 1'b0; tick(1);
        chk(sync_out == 1'b0, "R2 polarity restore", int'(sync_out), 0);

        // R3, R4, R7: pin-triggered burst, all lengths
        setmode(2, 2, 1'b0);
        for (int p = 0; p < 4; p++) begin
            pcnt = 2'(p); tick(2); clr();
            sync_pin = 1'b1; tick(90);
            sync_pin = 1'b0; tick(20);
            chk(rises == (1 << p), "R3 R4 pin burst length", rises, 1 << p);
            chk(bad_w == 0 && rise_after_tc == rises, "R7 burst pulse shape", bad_w, 0);
        end
        pcnt = 2'd1; tick(2); clr();
        sync_pol = 1'b1; tick(40);
        chk(rises == 2, "R4 polarity toggle burst", rises, 2);
        clr(); sync_pol = 1'b0; tick(40);
        chk(rises == 0, "R4 falling edge ignored", rises, 0);

        // R10: retrigger during burst
        pcnt = 2'd2; tick(2); clr();
        sync_pin = 1'b1; tick(20); sync_pin = 1'b0; tick(3);
        sync_pin = 1'b1; tick(90); sync_pin = 1'b0; tick(20);
        chk(rises == 4, "R10 retrigger ignored", rises, 4);

        // R5: write-triggered bursts
        setmode(3, 2, 1'b0);
        for (int p = 0; p < 4; p++) begin
            clr(); wr_pulse(p); tick(90);
            chk(rises == (1 << p), "R5 R3 write burst length", rises, 1 << p);
            chk(bad_w == 0, "R7 write burst width", bad_w, 0);
        end
        clr(); wr_pulse(1); tick(5); wr_pulse(3); tick(90);
        chk(rises == 2, "R10 write during burst ignored", rises, 2);
        clr(); sync_pin = 1'b1; tick(40); sync_pin = 1'b0; tick(20);
        chk(rises == 0, "R5 pin ignored in write mode", rises, 0);

        // R6: request-gated continuous SYSREF
        setmode(0, 2, 1'b1);
        sync_pin = 1'b1; tick(60); sync_pin = 1'b0; tick(40);
        chk(rises >= 6 && rises <= 9, "R6 request pulses", rises, 7);
        chk(bad_w == 0 && sync_out == 1'b0, "R7 request no runt", bad_w, 0);
        setmode(0, 2, 1'b0);
        sync_pin = 1'b1; tick(40); sync_pin = 1'b0; tick(10);
        chk(rises == 0, "R6 request disabled", rises, 0);

        // R9: continuous for every mode value
        for (int m = 0; m < 4; m++) begin
            setmode(m, 3, 1'b0);
            tick(80);
            chk(rises >= 9 && rises <= 11, "R9 continuous count", rises, 10);
            chk(bad_w == 0 && rise_after_tc == rises, "R7 continuous shape", bad_w, 0);
        end

        // R8: reclocked pin sync
        setmode(1, 1, 1'b0);
        sync_pin = 1'b1; tick(12);
        chk(rises == 1 && rise_on_tc == 1 && sync_out == 1'b1, "R8 reclocked rise",
            rise_on_tc, 1);
        sync_pin = 1'b0; tick(12);
        chk(sync_out == 1'b0, "R8 reclocked fall", int'(sync_out), 0);

        // R11: unlisted pairs
        for (int m = 0; m < 4; m++) begin
            for (int x = 0; x < 3; x++) begin
                if ((m == 1 && x <= 1) || (x == 2 && m != 1) || (m == 0 && x == 0))
                    continue;
                setmode(m, x, 1'b1);
                sync_pin = 1'b1; tick(20); sync_pin = 1'b0;
                wr_pulse(3); tick(40);
                chk(rises == 0 && sync_out == 1'b0, "R11 unlisted pair quiet",
                    rises, 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule